// File: doc/BRIEF.md
# Register-Indirect Effective Address Generator

This block forms the memory address for one operand of a load/store unit that owns eight 32-bit address registers and eight 32-bit data registers. Each cycle it can take one request. A request carries an addressing mode, an operand size, the number of the address register that forms the base, the number of an index register, and a 32-bit extension field taken from the instruction stream. The current contents of both register files also come in as flat buses. One cycle later the block returns a 24-bit effective address. For the two auto-modifying modes it also returns the updated 32-bit register value, the register number and a writeback strobe.

The block computes all offsets at full 32-bit width. Displacements and word-sized indices are sign-extended before the addition. Only the result is cut down to the address width. In the post-increment mode the memory access uses the old register value. In the pre-decrement mode the register is stepped down first and the access uses the stepped value. The step is one, two or four bytes, according to the operand size. The block does not access memory and does not decode instructions.

Top module: `ea_gen`

## Requirements
- R1: With mode code 0 (register indirect), the address is the low 24 bits of the selected address register, and no writeback is issued.
- R2: With mode code 1 (post-increment), the address is the old register value and the writeback value is that register plus the step. The step is 1, 2 or 4 for size codes 0, 1 and 2, and size code 3 also steps by 4.
- R3: With mode code 2 (pre-decrement), the writeback value is the register minus the step, and the address is the low 24 bits of that reduced value.
- R4: With mode code 3 (16-bit displacement), the address is the register plus ext[15:0] sign-extended to 32 bits, so 16'hFFFF subtracts one.
- R5: With mode code 4 (indexed), the address is register + sign-extended ext[7:0] + index. The index comes from the address file when idx_is_addr=1 and from the data file when idx_is_addr=0. It is the full 32-bit value when idx_long=1, and its low 16 bits sign-extended when idx_long=0.
- R6: With mode code 5 (absolute), the address is ext[23:0].
- R7: Every sum is formed at 32 bits, and the address output drops bits above bit 23.
- R8: ea_valid is high in the cycle after a cycle with req_valid high, and low after a cycle with req_valid low.
- R9: wb_en is high only in the cycle after a valid request in mode 1 or 2. When it is high, wb_reg equals the base register number of that request.
- R10: While rst is held and in the first cycle after it, ea_valid and wb_en are low.
- R11: Mode codes 6 and 7 behave as register indirect, with no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| size | input | 2 | Operand size code (0 byte, 1 word, 2/3 long) |
| areg_sel | input | 3 | Base address register number |
| idx_sel | input | 3 | Index register number |
| idx_is_addr | input | 1 | Index from address file (1) or data file (0) |
| idx_long | input | 1 | Use full 32-bit index (1) or sign-extended low word (0) |
| ext | input | 32 | Instruction extension field |
| areg_flat | input | 256 | Address register file, register n at bits [32n+31:32n] |
| dreg_flat | input | 256 | Data register file, same layout |
| ea_valid | output | 1 | Result valid |
| ea | output | 24 | Effective address |
| wb_en | output | 1 | Address register writeback strobe |
| wb_reg | output | 3 | Register to write back |
| wb_value | output | 32 | Updated register value |

## Verification
The hardest case to reach is a carry out of bit 23, or a wrap below zero, that must vanish from the address output. For pre-decrement the same wrap must still appear in the full 32-bit writeback value. Uniformly random register contents seldom put a base right at such a boundary. The stimulus therefore adds directed requests with bases near 24'hFFFFFF and near zero, and negative word indices whose upper half-word is non-zero, so that a missing sign extension or a missing truncation shows up. Random requests then mix all mode and size codes over random register files.

// File: rtl/eam_pkg.sv
package eam_pkg;

    localparam int XW = 32;

    localparam logic [2:0] MODE_IND     = 3'd0;
    localparam logic [2:0] MODE_POSTINC = 3'd1;
    localparam logic [2:0] MODE_PREDEC  = 3'd2;
    localparam logic [2:0] MODE_DISP    = 3'd3;
    localparam logic [2:0] MODE_INDEX   = 3'd4;
    localparam logic [2:0] MODE_ABS     = 3'd5;

    typedef struct packed {
        logic [XW-1:0] offset;
        logic [XW-1:0] delta;
        logic          zero_base;
        logic          wb;
    } eam_plan_t;

    function automatic logic [XW-1:0] size_step(input logic [1:0] sz);
        case (sz)
            2'd0:    size_step = XW'(1);
            2'd1:    size_step = XW'(2);
            default: size_step = XW'(4);
        endcase
    endfunction

    function automatic logic [XW-1:0] sx16(input logic [15:0] v);
        sx16 = {{(XW-16){v[15]}}, v};
    endfunction

    function automatic logic [XW-1:0] sx8(input logic [7:0] v);
        sx8 = {{(XW-8){v[7]}}, v};
    endfunction

endpackage

// File: rtl/eam_regsel.sv
module eam_regsel
    import eam_pkg::*;
#(
    parameter int NREG  = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [NREG*XW-1:0] areg_flat,
    input  logic [NREG*XW-1:0] dreg_flat,
    input  logic [SEL_W-1:0]   areg_sel,
    input  logic [SEL_W-1:0]   idx_sel,
    input  logic               idx_is_addr,
    output logic [XW-1:0]      base,
    output logic [XW-1:0]      idx_raw
);
    logic [XW-1:0] a_arr [NREG];
    logic [XW-1:0] d_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign a_arr[g] = areg_flat[g*XW +: XW];
        assign d_arr[g] = dreg_flat[g*XW +: XW];
    end

    always_comb begin
        base    = a_arr[areg_sel];
        idx_raw = idx_is_addr ? a_arr[idx_sel] : d_arr[idx_sel];
    end
endmodule

// File: rtl/eam_offset.sv
module eam_offset
    import eam_pkg::*;
(
    input  logic [2:0]    mode,
    input  logic [1:0]    size,
    input  logic [XW-1:0] ext,
    input  logic [XW-1:0] idx_raw,
    input  logic          idx_long,
    output eam_plan_t     plan
);
    logic [XW-1:0] step;
    logic [XW-1:0] idx_val;

    always_comb begin
        step    = size_step(size);
        idx_val = idx_long ? idx_raw : sx16(idx_raw[15:0]);
        plan    = '0;
        case (mode)
            MODE_POSTINC: begin
                plan.delta = step;
                plan.wb    = 1'b1;
            end
            MODE_PREDEC: begin
                plan.offset = -step;
                plan.delta  = -step;
                plan.wb     = 1'b1;
            end
            MODE_DISP:  plan.offset = sx16(ext[15:0]);
            MODE_INDEX: plan.offset = sx8(ext[7:0]) + idx_val;
            MODE_ABS: begin
                plan.offset    = ext;
                plan.zero_base = 1'b1;
            end
            default: plan = '0;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import eam_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NREG   = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [2:0]          mode,
    input  logic [1:0]          size,
    input  logic [SEL_W-1:0]    areg_sel,
    input  logic [SEL_W-1:0]    idx_sel,
    input  logic                idx_is_addr,
    input  logic                idx_long,
    input  logic [XW-1:0]       ext,
    input  logic [NREG*XW-1:0]  areg_flat,
    input  logic [NREG*XW-1:0]  dreg_flat,
    output logic                ea_valid,
    output logic [ADDR_W-1:0]   ea,
    output logic                wb_en,
    output logic [SEL_W-1:0]    wb_reg,
    output logic [XW-1:0]       wb_value
);
    logic [XW-1:0] base;
    logic [XW-1:0] idx_raw;
    eam_plan_t     plan;
    logic [XW-1:0] sum;
    logic [XW-1:0] new_reg;

    eam_regsel #(.NREG(NREG)) u_sel (
        .areg_flat   (areg_flat),
        .dreg_flat   (dreg_flat),
        .areg_sel    (areg_sel),
        .idx_sel     (idx_sel),
        .idx_is_addr (idx_is_addr),
        .base        (base),
        .idx_raw     (idx_raw)
    );

    eam_offset u_off (
        .mode     (mode),
        .size     (size),
        .ext      (ext),
        .idx_raw  (idx_raw),
        .idx_long (idx_long),
        .plan     (plan)
    );

    always_comb begin
        sum     = (plan.zero_base ? '0 : base) + plan.offset;
        new_reg = base + plan.delta;
    end

    if (ADDR_W < XW) begin : g_hi
        logic unused_sum_hi;
        assign unused_sum_hi = ^sum[XW-1:ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_valid <= 1'b0;
            wb_en    <= 1'b0;
            ea       <= '0;
            wb_reg   <= '0;
            wb_value <= '0;
        end else begin
            ea_valid <= req_valid;
            wb_en    <= req_valid & plan.wb;
            if (req_valid) begin
                ea       <= sum[ADDR_W-1:0];
                wb_reg   <= areg_sel;
                wb_value <= new_reg;
            end
        end
    end
endmodule

// File: rtl/eam_checker.sv
module eam_checker
    import eam_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NREG   = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [2:0]         mode,
    input logic [1:0]         size,
    input logic [SEL_W-1:0]   areg_sel,
    input logic [XW-1:0]      ext,
    input logic [NREG*XW-1:0] areg_flat,
    input logic               ea_valid,
    input logic [ADDR_W-1:0]  ea,
    input logic               wb_en,
    input logic [SEL_W-1:0]   wb_reg,
    input logic [XW-1:0]      wb_value
);
    logic [XW-1:0] chk_base;
    logic [XW-1:0] chk_step;
    assign chk_base = areg_flat[areg_sel*XW +: XW];
    assign chk_step = (size == 2'd0) ? XW'(1) : (size == 2'd1) ? XW'(2) : XW'(4);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ea_valid);
    p_idle_follows_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !ea_valid);
    p_wb_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ea_valid);
    p_wb_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == MODE_POSTINC) |=> (wb_en && wb_reg == $past(areg_sel)));
    p_postinc_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == MODE_POSTINC) |=>
        (wb_value == $past(chk_base) + $past(chk_step) && ea == $past(chk_base[ADDR_W-1:0])));
    p_predec_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == MODE_PREDEC) |=>
        (wb_en && ea == wb_value[ADDR_W-1:0] && wb_value == $past(chk_base) - $past(chk_step)));
    p_indirect_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == MODE_IND) |=> (!wb_en && ea == $past(chk_base[ADDR_W-1:0])));
    p_absolute_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == MODE_ABS) |=> (!wb_en && ea == $past(ext[ADDR_W-1:0])));
endmodule

bind ea_gen eam_checker #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mode      (mode),
    .size      (size),
    .areg_sel  (areg_sel),
    .ext       (ext),
    .areg_flat (areg_flat),
    .ea_valid  (ea_valid),
    .ea        (ea),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .wb_value  (wb_value)
);

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [2:0]  areg_sel = '0;
    logic [2:0]  idx_sel = '0;
    logic        idx_is_addr = 1'b0;
    logic        idx_long = 1'b0;
    logic [31:0] ext = '0;
    logic [255:0] areg_flat;
    logic [255:0] dreg_flat;
    logic        ea_valid;
    logic [23:0] ea;
    logic        wb_en;
    logic [2:0]  wb_reg;
    logic [31:0] wb_value;

    logic [31:0] A [8];
    logic [31:0] D [8];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            areg_flat[i*32 +: 32] = A[i];
            dreg_flat[i*32 +: 32] = D[i];
        end
    end

    ea_gen dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .size(size),
        .areg_sel(areg_sel), .idx_sel(idx_sel), .idx_is_addr(idx_is_addr),
        .idx_long(idx_long), .ext(ext), .areg_flat(areg_flat), .dreg_flat(dreg_flat),
        .ea_valid(ea_valid), .ea(ea), .wb_en(wb_en), .wb_reg(wb_reg), .wb_value(wb_value)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input logic [1:0] s);
        return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic run_req(input string tag, input logic [2:0] m, input logic [1:0] s,
                           input logic [2:0] as, input logic [2:0] is, input logic ia,
                           input logic il, input logic [31:0] x);
        logic [31:0] base, idx, e, nv;
        logic wb;
        @(negedge clk);
        req_valid = 1'b1; mode = m; size = s; areg_sel = as; idx_sel = is;
        idx_is_addr = ia; idx_long = il; ext = x;
        base = A[as];
        idx = ia ? A[is] : D[is];
        if (!il) idx = {{16{idx[15]}}, idx[15:0]};
        wb = 1'b0; nv = base; e = base;
        case (m)
            3'd1: begin wb = 1'b1; nv = base + step_of(s); end
            3'd2: begin wb = 1'b1; nv = base - step_of(s); e = nv; end
            3'd3: e = base + {{16{x[15]}}, x[15:0]};
            3'd4: e = base + {{24{x[7]}}, x[7:0]} + idx;
            3'd5: e = x;
            default: e = base;
        endcase
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check({tag, " R8 valid"}, {31'd0, ea_valid}, 32'd1);
        check({tag, " R7 ea"}, {8'd0, ea}, {8'd0, e[23:0]});
        check({tag, " R9 wb_en"}, {31'd0, wb_en}, {31'd0, wb});
        if (wb) begin
            check({tag, " wb_value"}, wb_value, nv);
            check({tag, " R9 wb_reg"}, {29'd0, wb_reg}, {29'd0, as});
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) begin A[i] = 32'h0000_2000 + 32'(i*4); D[i] = 32'd0; end
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset ea_valid", {31'd0, ea_valid}, 32'd0);
        check("R10 reset wb_en", {31'd0, wb_en}, 32'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R10 after reset ea_valid", {31'd0, ea_valid}, 32'd0);

        A[1] = 32'h0000_2004; D[2] = 32'h0000_0005;
        run_req("R5 sum", 3'd4, 2'd2, 3'd1, 3'd2, 1'b0, 1'b0, 32'h0000_0003);
        check("R5 example", {8'd0, ea}, 32'h0000_200C);
        A[4] = 32'h0000_3000;
        run_req("R4 minus one", 3'd3, 2'd0, 3'd4, 3'd0, 1'b0, 1'b0, 32'h0000_FFFF);
        check("R4 example", {8'd0, ea}, 32'h0000_2FFF);
        D[3] = 32'h1234_FFF0;
        run_req("R5 word index neg", 3'd4, 2'd1, 3'd4, 3'd3, 1'b0, 1'b0, 32'h0000_0080);
        run_req("R5 long index", 3'd4, 2'd1, 3'd4, 3'd3, 1'b0, 1'b1, 32'h0000_007F);
        A[6] = 32'h0000_0100;
        run_req("R5 addr index", 3'd4, 2'd0, 3'd4, 3'd6, 1'b1, 1'b0, 32'h0000_0001);
        for (int s = 0; s < 4; s++) begin
            A[0] = 32'h0000_2000;
            run_req("R2 step", 3'd1, 2'(s), 3'd0, 3'd0, 1'b0, 1'b0, 32'd0);
            run_req("R3 step", 3'd2, 2'(s), 3'd0, 3'd0, 1'b0, 1'b0, 32'd0);
        end
        A[5] = 32'h12FF_FFFF;
        run_req("R7 carry", 3'd3, 2'd0, 3'd5, 3'd0, 1'b0, 1'b0, 32'h0000_0001);
        check("R7 carry dropped", {8'd0, ea}, 32'd0);
        A[5] = 32'h0000_0000;
        run_req("R7 wrap predec", 3'd2, 2'd2, 3'd5, 3'd0, 1'b0, 1'b0, 32'd0);
        check("R3 wrap wb_value", wb_value, 32'hFFFF_FFFC);
        run_req("R6 abs", 3'd5, 2'd0, 3'd5, 3'd0, 1'b0, 1'b0, 32'hAB12_3456);
        run_req("R11 mode6", 3'd6, 2'd1, 3'd6, 3'd0, 1'b0, 1'b0, 32'h0000_1234);
        run_req("R11 mode7", 3'd7, 2'd2, 3'd4, 3'd0, 1'b0, 1'b0, 32'h0000_1234);

        @(negedge clk);
        req_valid = 1'b0; mode = 3'd1;
        @(posedge clk); #1;
        check("R8 idle ea_valid", {31'd0, ea_valid}, 32'd0);
        check("R9 idle wb_en", {31'd0, wb_en}, 32'd0);

        for (int n = 0; n < 400; n++) begin
            logic [2:0] m;
            for (int i = 0; i < 8; i++) begin
                A[i] = $urandom;
                D[i] = $urandom;
                if ($urandom % 4 == 0) A[i] = 32'h00FF_FFF0 + ($urandom % 32);
            end
            m = 3'($urandom);
            run_req(tag_of(m), m, 2'($urandom), 3'($urandom), 3'($urandom),
                    1'($urandom), 1'($urandom), $urandom);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule